// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This unit turns a two-part logical address into a physical address. The two parts are a segment number and an offset inside that segment. A small table of segment descriptors is held on chip. Each descriptor holds a base address, a length (limit), a present flag and three access-right flags: read, write and execute. A separate register holds the number of segments in use. Configuration software loads the descriptors and that count through a simple write port.

Each lookup is sampled on a clock edge while the request strobe is high. The segment number is checked against the count, then against the present flag, then the offset against the limit, then the access kind against the rights. If every check passes, base plus offset is returned. If any check fails, a trap is returned instead, together with a cause code that names the highest-priority failure. The result is registered, so it appears one clock after the request.

Top module: `segxlate_top`

## Requirements
- R1: After a synchronous reset, rsp_valid is low, the segment count is zero and every descriptor is marked absent, so the first lookup traps with cause 1.
- R2: A request sampled with req_valid high yields rsp_valid high exactly one cycle later. rsp_valid is low in any cycle that follows a cycle without a request. Back-to-back requests give back-to-back responses in order.
- R3: A segment number greater than or equal to the programmed count traps with cause 1 (out of range). A number one below the count is accepted.
- R4: A descriptor whose present flag is 0 traps with cause 2 (absent).
- R5: An offset greater than or equal to the descriptor limit traps with cause 3 (limit). An offset of limit minus 1 is accepted.
- R6: The access kind on req_acc is 0 for read, 1 for write, 2 for execute and 3 for reserved. The rights field cfg_perm holds read in bit 0, write in bit 1 and execute in bit 2. An access kind whose right bit is clear traps with cause 4 (permission). Kind 3 always traps with cause 4.
- R7: When no check fails, rsp_trap is 0, rsp_cause is 0 and rsp_paddr equals base plus the zero-extended offset, modulo 2^PA_W.
- R8: When several checks fail, the cause reported is the first failure in this order: out of range (1), absent (2), limit (3), permission (4).
- R9: Whenever rsp_trap is high, rsp_paddr is 0.
- R10: A lookup in the same cycle as a descriptor write to the same segment uses the old descriptor. The next lookup uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tbl_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | SEG_W | Descriptor index to write |
| cfg_base | input | PA_W | Segment base address |
| cfg_limit | input | OFF_W+1 | Segment length |
| cfg_valid | input | 1 | Present flag |
| cfg_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cfg_cnt_we | input | 1 | Segment count write strobe |
| cfg_cnt | input | SEG_W+1 | Number of segments in use |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within segment |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_trap | output | 1 | Translation refused |
| rsp_cause | output | 3 | 0 none, 1 range, 2 absent, 3 limit, 4 permission |
| rsp_paddr | output | PA_W | Physical address, 0 on trap |

## Verification
Every response is due on the first rising edge after the request is sampled, and configuration writes take effect at the edge that samples them. The bench drives inputs on the falling edge, drops the request one falling edge later, and reads the response at that same falling edge, half a cycle after the output registers load. The pipelined case holds a second request during that read, so a response that came one cycle late would be seen. The same-cycle write case reads the old descriptor at that point and reads the new one on the lookup that follows.

// File: rtl/segxlate_pkg.sv
package segxlate_pkg;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_RANGE = 3'd1,
    CAUSE_ABSNT = 3'd2,
    CAUSE_LIMIT = 3'd3,
    CAUSE_PERM  = 3'd4
  } cause_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

endpackage

// File: rtl/segxlate_table.sv
module segxlate_table
  import segxlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [OFF_W:0]    wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [PA_W-1:0]   rd_base,
  output logic [OFF_W:0]    rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm
);
  localparam int NUM_SEG = 1 << SEG_W;

  // Data fields: plain storage, no reset, written like distributed RAM.
  logic [PA_W-1:0]   base_mem  [NUM_SEG];
  logic [OFF_W:0]    limit_mem [NUM_SEG];
  logic [PERM_W-1:0] perm_mem  [NUM_SEG];
  // Present flags: cleared by reset so an unloaded table refuses everything.
  logic [NUM_SEG-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx]  <= wr_base;
      limit_mem[wr_idx] <= wr_limit;
      perm_mem[wr_idx]  <= wr_perm;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_vld
      always_ff @(posedge clk) begin
        if (rst)
          valid_q[g] <= 1'b0;
        else if (wr_en && (wr_idx == SEG_W'(g)))
          valid_q[g] <= wr_valid;
      end
    end
  endgenerate

  // Asynchronous read: the lookup sees contents before any same-edge write.
  assign rd_base  = base_mem[rd_idx];
  assign rd_limit = limit_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
  assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/segxlate_check.sv
module segxlate_check
  import segxlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [SEG_W:0]    seg_count,
  input  logic [PA_W-1:0]   ent_base,
  input  logic [OFF_W:0]    ent_limit,
  input  logic              ent_valid,
  input  logic [PERM_W-1:0] ent_perm,
  output logic              trap,
  output cause_e            cause,
  output logic [PA_W-1:0]   paddr
);
  logic out_of_range;
  logic absent;
  logic over_limit;
  logic denied;

  always_comb begin
    out_of_range = ({1'b0, seg} >= seg_count);
    absent       = !ent_valid;
    over_limit   = ({1'b0, off} >= ent_limit);
    unique case (acc_e'(acc))
      ACC_RD:  denied = !ent_perm[PERM_RD];
      ACC_WR:  denied = !ent_perm[PERM_WR];
      ACC_EX:  denied = !ent_perm[PERM_EX];
      default: denied = 1'b1;
    endcase
  end

  // Fixed priority: range, absent, limit, permission.
  always_comb begin
    if (out_of_range)    cause = CAUSE_RANGE;
    else if (absent)     cause = CAUSE_ABSNT;
    else if (over_limit) cause = CAUSE_LIMIT;
    else if (denied)     cause = CAUSE_PERM;
    else                 cause = CAUSE_NONE;
  end

  assign trap  = (cause != CAUSE_NONE);
  assign paddr = trap ? '0 : (ent_base + PA_W'(off));

endmodule

// File: rtl/segxlate_top.sv
module segxlate_top
  import segxlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_tbl_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [OFF_W:0]    cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_cnt_we,
  input  logic [SEG_W:0]    cfg_cnt,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [2:0]        rsp_cause,
  output logic [PA_W-1:0]   rsp_paddr
);
  logic [SEG_W:0]    seg_count_q;
  logic [PA_W-1:0]   e_base;
  logic [OFF_W:0]    e_limit;
  logic              e_valid;
  logic [PERM_W-1:0] e_perm;
  logic              c_trap;
  cause_e            c_cause;
  logic [PA_W-1:0]   c_paddr;

  always_ff @(posedge clk) begin
    if (rst)
      seg_count_q <= '0;
    else if (cfg_cnt_we)
      seg_count_q <= cfg_cnt;
  end

  segxlate_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_tbl_we),
    .wr_idx   (cfg_idx),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .wr_valid (cfg_valid),
    .wr_perm  (cfg_perm),
    .rd_idx   (req_seg),
    .rd_base  (e_base),
    .rd_limit (e_limit),
    .rd_valid (e_valid),
    .rd_perm  (e_perm)
  );

  segxlate_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) check_i (
    .seg       (req_seg),
    .off       (req_off),
    .acc       (req_acc),
    .seg_count (seg_count_q),
    .ent_base  (e_base),
    .ent_limit (e_limit),
    .ent_valid (e_valid),
    .ent_perm  (e_perm),
    .trap      (c_trap),
    .cause     (c_cause),
    .paddr     (c_paddr)
  );

  // Single output register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= 3'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_trap  <= c_trap;
        rsp_cause <= c_cause;
        rsp_paddr <= c_paddr;
      end else begin
        rsp_trap  <= 1'b0;
        rsp_cause <= 3'd0;
        rsp_paddr <= '0;
      end
    end
  end

endmodule

// File: rtl/segxlate_chk.sv
module segxlate_chk #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic [SEG_W:0]   seg_count,
  input logic             rsp_valid,
  input logic             rsp_trap,
  input logic [2:0]       rsp_cause,
  input logic [PA_W-1:0]  rsp_paddr
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3
  range_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_seg} >= seg_count)) |=> (rsp_trap && rsp_cause == 3'd1));

  // R9
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_paddr == '0));

  // R8
  cause_matches_trap_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_trap == (rsp_cause != 3'd0)) && (rsp_cause <= 3'd4));

  // R2
  idle_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_trap);

endmodule

bind segxlate_top segxlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_seg   (req_seg),
  .seg_count (seg_count_q),
  .rsp_valid (rsp_valid),
  .rsp_trap  (rsp_trap),
  .rsp_cause (rsp_cause),
  .rsp_paddr (rsp_paddr)
);

// File: tb/segxlate_tb_top.sv
module segxlate_tb_top;
  localparam int SEG_W = 3;
  localparam int OFF_W = 12;
  localparam int PA_W  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_tbl_we = 1'b0;
  logic [SEG_W-1:0] cfg_idx = '0;
  logic [PA_W-1:0]  cfg_base = '0;
  logic [OFF_W:0]   cfg_limit = '0;
  logic             cfg_valid = 1'b0;
  logic [2:0]       cfg_perm = '0;
  logic             cfg_cnt_we = 1'b0;
  logic [SEG_W:0]   cfg_cnt = '0;
  logic             req_valid = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0]       req_acc = '0;
  logic             rsp_valid;
  logic             rsp_trap;
  logic [2:0]       rsp_cause;
  logic [PA_W-1:0]  rsp_paddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  segxlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (.*);

  task automatic expect_rsp(input string tag, input logic t, input logic [2:0] c,
                            input logic [PA_W-1:0] pa);
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_trap !== t || rsp_cause !== c || rsp_paddr !== pa) begin
      n_fail++;
      $display("FAIL %s: got v=%b trap=%b cause=%0d pa=%h, want v=1 trap=%b cause=%0d pa=%h",
               tag, rsp_valid, rsp_trap, rsp_cause, rsp_paddr, t, c, pa);
    end
  endtask

  task automatic put_entry(input int idx, input logic [PA_W-1:0] b, input int lim,
                           input logic v, input logic [2:0] p);
    @(negedge clk);
    cfg_tbl_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_base = b;
    cfg_limit = (OFF_W+1)'(lim); cfg_valid = v; cfg_perm = p;
    @(negedge clk);
    cfg_tbl_we = 1'b0;
  endtask

  task automatic put_count(input int n);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt = (SEG_W+1)'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  // Single lookup: response loads on the next rising edge, read at the falling edge after it.
  task automatic lookup(input string tag, input int s, input int o, input int a,
                        input logic t, input logic [2:0] c, input logic [PA_W-1:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_seg = SEG_W'(s); req_off = OFF_W'(o); req_acc = 2'(a);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, t, c, pa);
  endtask

  task automatic t_reset;
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rsp_valid=%b want 0", rsp_valid);
    end
    lookup("R1 first lookup after reset", 0, 0, 0, 1'b1, 3'd1, '0);
  endtask

  task automatic t_load;
    put_count(4);
    put_entry(0, 16'h1000, 12'h100, 1'b1, 3'b111);
    put_entry(1, 16'hFF00, 12'h800, 1'b1, 3'b001);
    put_entry(2, 16'h3000, 12'h0,   1'b0, 3'b000);
    put_entry(3, 16'h0200, 12'h10,  1'b1, 3'b100);
    put_entry(4, 16'h4000, 12'h100, 1'b1, 3'b111);
    put_entry(5, 16'h5000, 12'h100, 1'b0, 3'b000);
  endtask

  task automatic t_translate;
    lookup("R7 seg0 read",               0, 12'h0FF, 0, 1'b0, 3'd0, 16'h10FF);
    lookup("R7 seg1 read wraps",         1, 12'h1FF, 0, 1'b0, 3'd0, 16'h00FF);
    lookup("R7 seg3 exec",               3, 12'h00F, 2, 1'b0, 3'd0, 16'h020F);
    lookup("R7 seg0 write off 0",        0, 0,       1, 1'b0, 3'd0, 16'h1000);
  endtask

  task automatic t_range;
    lookup("R3 seg4 equals count",       4, 0, 0, 1'b1, 3'd1, '0);
    lookup("R3 seg7 beyond count",       7, 0, 0, 1'b1, 3'd1, '0);
    lookup("R3 seg3 last legal",         3, 0, 2, 1'b0, 3'd0, 16'h0200);
  endtask

  task automatic t_absent;
    lookup("R4 seg2 absent",             2, 0, 0, 1'b1, 3'd2, '0);
  endtask

  task automatic t_limit;
    lookup("R5 off equals limit",        0, 12'h100, 0, 1'b1, 3'd3, '0);
    lookup("R5 off far past limit",      3, 12'hFFF, 2, 1'b1, 3'd3, '0);
  endtask

  task automatic t_perm;
    lookup("R6 write on read-only",      1, 0, 1, 1'b1, 3'd4, '0);
    lookup("R6 exec on read-only",       1, 0, 2, 1'b1, 3'd4, '0);
    lookup("R6 read on exec-only",       3, 0, 0, 1'b1, 3'd4, '0);
    lookup("R6 reserved kind on rwx",    0, 0, 3, 1'b1, 3'd4, '0);
  endtask

  task automatic t_priority;
    lookup("R8 range over absent",       5, 12'hFFF, 3, 1'b1, 3'd1, '0);
    lookup("R8 absent over limit/perm",  2, 12'hFFF, 3, 1'b1, 3'd2, '0);
    lookup("R8 limit over perm",         1, 12'h900, 1, 1'b1, 3'd3, '0);
  endtask

  task automatic t_pipeline;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'd0; req_off = 12'h010; req_acc = 2'd0;
    @(negedge clk);
    req_seg = 3'd2; req_off = 12'h0; req_acc = 2'd0;
    expect_rsp("R2 back-to-back first", 1'b0, 3'd0, 16'h1010);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R2 back-to-back second", 1'b1, 3'd2, '0);
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle: rsp_valid=%b want 0", rsp_valid);
    end
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_tbl_we = 1'b1; cfg_idx = 3'd0; cfg_base = 16'h2000;
    cfg_limit = 13'h100; cfg_valid = 1'b1; cfg_perm = 3'b111;
    req_valid = 1'b1; req_seg = 3'd0; req_off = 12'h001; req_acc = 2'd0;
    @(negedge clk);
    cfg_tbl_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R10 same-cycle uses old entry", 1'b0, 3'd0, 16'h1001);
    lookup("R10 next lookup uses new entry", 0, 12'h001, 0, 1'b0, 3'd0, 16'h2001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_load;
    t_translate;
    t_range;
    t_absent;
    t_limit;
    t_perm;
    t_priority;
    t_pipeline;
    t_same_cycle;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung want done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule